// File: doc/BRIEF.md
# Stereo/Mono Digital Audio Subframe Transmitter Controller

This block turns a pair of parallel 24-bit audio samples and two 192-bit channel-status blocks into the two subframes of each frame on a consumer digital audio line (IEC 60958 style). It chooses which audio word, validity bit and channel-status bit go into each subframe, computes even parity, and sends the result as a biphase-mark coded line. Preamble generation and line coding are done by a small serializer that is clocked by a half-cell strobe.

An 8-bit control byte selects line off, mute, validity level, mono operation, the channel-status source and the mono channel. The byte is written into a holding register at any time. It is copied into the active setting only at a frame boundary. The input samples are captured at the same boundary, so a frame is never built from mixed settings or mixed samples. The parallel subframe outputs show the word that is being sent, so neighbouring logic can observe it.

Top module: `iec_tx_ctrl`

## Requirements
- R1: While the active control has bit 5 (line off) set, tx_line stays at logic 0 for every half-cell of the frame. Framing continues internally while the line is off.
- R2: While bit 4 (mute) is active, the audio field of both subframes is all zeros. The preambles, V, C and parity are still sent.
- R3: The V bit of both subframes equals control bit 3. A value of 0 means valid linear PCM and a value of 1 means invalid or non-linear data.
- R4: With bit 2 (mono) clear, subframe A carries the sample on smp_a_in and subframe B carries the sample on smp_b_in.
- R5: With bit 2 set, both subframes carry one sample. Bit 0 selects it: 0 selects smp_a_in and 1 selects smp_b_in.
- R6: With bit 1 clear, subframe A takes its C bit from cs_blk_a and subframe B takes it from cs_blk_b. With bit 1 set, both subframes take their C bit from the block chosen by bit 0, whatever the state of bit 2.
- R7: A frame index counts frames from 0 after reset and wraps from 191 to 0. The index picks the C bit of the current frame. Subframe A of frame 0 starts with the block-start preamble, with half-cell levels 1,1,1,0,1,0,0,0. The other A subframes use 1,1,1,0,0,0,1,0. Every B subframe uses 1,1,1,0,0,1,0,0.
- R8: A subframe has 32 slots of two half-cells each. Slots 0-3 hold the preamble. Slots 4-27 hold the audio, LSB first. Slot 28 is V, slot 29 is U (always 0), slot 30 is C and slot 31 is P. P makes slots 4-31 even parity, so every subframe ends at the level it started from (low). In slots 4-31 the level changes at every slot start, and it also changes at mid-slot for a 1.
- R9: A control write and new input samples take effect only at the next frame boundary, so a frame in progress is not affected. A write made in the same cycle as the boundary applies one frame later.
- R10: Control bits 7:6 (input format) do not change the transmitted subframes.
- R11: After reset, tx_line is low, the active control and the captured samples are zero, and the first frame is frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_en | input | 1 | Half-cell strobe that advances the line by one half-cell |
| ctrl_wr | input | 1 | Writes ctrl_wdata into the holding control register |
| ctrl_wdata | input | 8 | Control byte: 7:6 format, 5 off, 4 mute, 3 V, 2 mono, 1 C source, 0 mono channel |
| smp_a_in | input | AW | Channel A sample, captured at the frame boundary |
| smp_b_in | input | AW | Channel B sample, captured at the frame boundary |
| cs_blk_a | input | FRAMES | Channel A channel-status block, bit n sent in frame n |
| cs_blk_b | input | FRAMES | Channel B channel-status block |
| tx_line | output | 1 | Biphase-mark coded line output |
| sf_is_b | output | 1 | High while subframe B is being sent |
| sf_audio | output | AW | Audio field of the current subframe |
| sf_v | output | 1 | V bit of the current subframe |
| sf_c | output | 1 | C bit of the current subframe |
| sf_par | output | 1 | Parity bit of the current subframe |

## Verification
The assertions rely on two things about the inputs. First, cell_en and ctrl_wr are synchronous single-cycle strobes. Second, the channel-status blocks are held steady, so the subframe contents depend only on the captured state. The stimulus draws the two blocks once and never changes them. It changes samples and control only between strobes, and in a few frames it writes the control byte in the same cycle as the boundary strobe. Randomly chosen control bytes clear the line-off bit in most frames, so the decoded line content is checked often.

// File: rtl/iec_tx_pkg.sv
package iec_tx_pkg;

  typedef struct packed {
    logic [1:0] fmt;
    logic       off;
    logic       mute;
    logic       vbit;
    logic       mono;
    logic       cs_sel;
    logic       ch_sel;
  } tx_ctrl_t;

  typedef enum logic [1:0] {
    PRE_START = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // Bit i set: line level changes at the start of preamble half-cell i.
  function automatic logic [7:0] pre_toggles(input pre_kind_e kind);
    case (kind)
      PRE_START: pre_toggles = 8'b0011_1001;
      PRE_LEFT:  pre_toggles = 8'b1100_1001;
      default:   pre_toggles = 8'b0110_1001;
    endcase
  endfunction

endpackage

// File: rtl/iec_tx_timebase.sv
module iec_tx_timebase #(
  parameter int HC_FRAME = 128,
  parameter int FRAMES   = 192,
  localparam int HCW     = $clog2(HC_FRAME),
  localparam int FW      = $clog2(FRAMES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cell_en,
  output logic [HCW-1:0] hc,
  output logic [FW-1:0]  frm,
  output logic           frame_end
);

  logic [HCW-1:0] hc_q, hc_d;
  logic [FW-1:0]  frm_q, frm_d;

  assign frame_end = cell_en && (hc_q == HCW'(HC_FRAME - 1));
  assign hc  = hc_q;
  assign frm = frm_q;

  always_comb begin
    hc_d  = hc_q;
    frm_d = frm_q;
    if (cell_en) begin
      if (hc_q == HCW'(HC_FRAME - 1)) begin
        hc_d  = '0;
        frm_d = (frm_q == FW'(FRAMES - 1)) ? '0 : frm_q + 1'b1;
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc_q  <= '0;
      frm_q <= '0;
    end else begin
      hc_q  <= hc_d;
      frm_q <= frm_d;
    end
  end

  assert_frame_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && (frm_q == FW'(FRAMES - 1)) |=> frm_q == '0);

  assert_frame_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= FW'(FRAMES - 1));

endmodule

// File: rtl/iec_tx_payload.sv
module iec_tx_payload
  import iec_tx_pkg::*;
#(
  parameter int AW = 24
) (
  input  tx_ctrl_t      ctrl,
  input  logic          is_b,
  input  logic [AW-1:0] smp_a,
  input  logic [AW-1:0] smp_b,
  input  logic          cs_a,
  input  logic          cs_b,
  output logic [AW-1:0] audio,
  output logic          v,
  output logic          c,
  output logic          par
);

  logic aud_from_b;
  logic cs_from_b;

  always_comb begin
    aud_from_b = ctrl.mono ? ctrl.ch_sel : is_b;
    cs_from_b  = ctrl.cs_sel ? ctrl.ch_sel : is_b;
    audio      = ctrl.mute ? '0 : (aud_from_b ? smp_b : smp_a);
    v          = ctrl.vbit;
    c          = cs_from_b ? cs_b : cs_a;
    par        = ^{audio, v, 1'b0, c};
  end

endmodule

// File: rtl/iec_tx_serializer.sv
module iec_tx_serializer
  import iec_tx_pkg::*;
#(
  parameter int AW     = 24,
  localparam int SLOTS = AW + 8,
  localparam int SHW   = $clog2(2 * SLOTS),
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cell_en,
  input  logic [SHW-1:0] hs,
  input  pre_kind_e      pre,
  input  logic [AW-1:0]  audio,
  input  logic           v,
  input  logic           c,
  input  logic           par,
  input  logic           off,
  output logic           tx_line
);

  logic [SLOTS-1:0] word;
  logic [7:0]       pmask;
  logic [SW-1:0]    slot;
  logic             toggle;
  logic             lvl_q, lvl_d;
  logic             line_q, line_d;

  assign word  = {par, c, 1'b0, v, audio, 4'b0000};
  assign pmask = pre_toggles(pre);
  assign slot  = hs[SHW-1:1];

  always_comb begin
    if (slot < SW'(4))
      toggle = pmask[hs[2:0]];
    else if (!hs[0])
      toggle = 1'b1;
    else
      toggle = word[slot];
    lvl_d  = lvl_q;
    line_d = line_q;
    if (cell_en) begin
      lvl_d  = lvl_q ^ toggle;
      line_d = !off && lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      line_q <= line_d;
    end
  end

  assign tx_line = line_q;

  // Even parity over slots 4-31 and four preamble changes bring the level back low.
  assert_subframe_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && (hs == SHW'(2 * SLOTS - 1)) |=> !lvl_q);

  assert_line_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && off |=> !tx_line);

endmodule

// File: rtl/iec_tx_ctrl.sv
module iec_tx_ctrl
  import iec_tx_pkg::*;
#(
  parameter int AW     = 24,
  parameter int FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_en,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_wdata,
  input  logic [AW-1:0]     smp_a_in,
  input  logic [AW-1:0]     smp_b_in,
  input  logic [FRAMES-1:0] cs_blk_a,
  input  logic [FRAMES-1:0] cs_blk_b,
  output logic              tx_line,
  output logic              sf_is_b,
  output logic [AW-1:0]     sf_audio,
  output logic              sf_v,
  output logic              sf_c,
  output logic              sf_par
);

  localparam int SLOTS    = AW + 8;
  localparam int SF_HC    = 2 * SLOTS;
  localparam int HC_FRAME = 2 * SF_HC;
  localparam int HCW      = $clog2(HC_FRAME);
  localparam int FW       = $clog2(FRAMES);
  localparam int SHW      = $clog2(SF_HC);

  logic [1:0]     rst_pipe;
  logic           rst_int_n;
  tx_ctrl_t       ctrl_pend_q, ctrl_pend_d;
  tx_ctrl_t       ctrl_act_q, ctrl_act_d;
  logic [AW-1:0]  smp_a_q, smp_a_d, smp_b_q, smp_b_d;
  logic [HCW-1:0] hc;
  logic [FW-1:0]  frm;
  logic           frame_end;
  logic [SHW-1:0] hs;
  pre_kind_e      pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  iec_tx_timebase #(.HC_FRAME(HC_FRAME), .FRAMES(FRAMES)) u_time (
    .clk(clk), .rst_n(rst_int_n), .cell_en(cell_en),
    .hc(hc), .frm(frm), .frame_end(frame_end)
  );

  always_comb begin
    ctrl_pend_d = ctrl_wr ? tx_ctrl_t'(ctrl_wdata) : ctrl_pend_q;
    ctrl_act_d  = frame_end ? ctrl_pend_q : ctrl_act_q;
    smp_a_d     = frame_end ? smp_a_in : smp_a_q;
    smp_b_d     = frame_end ? smp_b_in : smp_b_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_pend_q <= '0;
      ctrl_act_q  <= '0;
      smp_a_q     <= '0;
      smp_b_q     <= '0;
    end else begin
      ctrl_pend_q <= ctrl_pend_d;
      ctrl_act_q  <= ctrl_act_d;
      smp_a_q     <= smp_a_d;
      smp_b_q     <= smp_b_d;
    end
  end

  always_comb begin
    sf_is_b = (hc >= HCW'(SF_HC));
    hs      = sf_is_b ? SHW'(hc - HCW'(SF_HC)) : SHW'(hc);
    if (sf_is_b)         pre = PRE_RIGHT;
    else if (frm == '0)  pre = PRE_START;
    else                 pre = PRE_LEFT;
  end

  iec_tx_payload #(.AW(AW)) u_pay (
    .ctrl(ctrl_act_q), .is_b(sf_is_b), .smp_a(smp_a_q), .smp_b(smp_b_q),
    .cs_a(cs_blk_a[frm]), .cs_b(cs_blk_b[frm]),
    .audio(sf_audio), .v(sf_v), .c(sf_c), .par(sf_par)
  );

  iec_tx_serializer #(.AW(AW)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .cell_en(cell_en), .hs(hs), .pre(pre),
    .audio(sf_audio), .v(sf_v), .c(sf_c), .par(sf_par),
    .off(ctrl_act_q.off), .tx_line(tx_line)
  );

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_end |=> $stable(ctrl_act_q));

  assert_sample_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_end |=> $stable(smp_a_q) && $stable(smp_b_q));

  assert_mute_zero_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_act_q.mute |-> sf_audio == '0);

endmodule

// File: tb/iec_tx_ctrl_test.sv
module iec_tx_ctrl_test;

  localparam int AW = 24;
  localparam int FRAMES = 192;
  localparam int NFRAMES = 200;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cell_en = 1'b0;
  logic              ctrl_wr = 1'b0;
  logic [7:0]        ctrl_wdata = '0;
  logic [AW-1:0]     smp_a_in = '0;
  logic [AW-1:0]     smp_b_in = '0;
  logic [FRAMES-1:0] cs_blk_a = '0;
  logic [FRAMES-1:0] cs_blk_b = '0;
  logic              tx_line, sf_is_b, sf_v, sf_c, sf_par;
  logic [AW-1:0]     sf_audio;

  iec_tx_ctrl #(.AW(AW), .FRAMES(FRAMES)) uut (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .smp_a_in(smp_a_in), .smp_b_in(smp_b_in),
    .cs_blk_a(cs_blk_a), .cs_blk_b(cs_blk_b), .tx_line(tx_line),
    .sf_is_b(sf_is_b), .sf_audio(sf_audio), .sf_v(sf_v), .sf_c(sf_c),
    .sf_par(sf_par)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench model of the state that governs the frame on the line.
  logic [7:0]    m_ctrl, m_pend;
  logic [AW-1:0] m_a, m_b;
  int            m_frm;
  logic          lv [0:127];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_audio(input bit side);
    bit from_b;
    from_b = m_ctrl[2] ? m_ctrl[0] : side;
    if (m_ctrl[4]) return '0;
    return from_b ? m_b : m_a;
  endfunction

  function automatic logic exp_c(input bit side);
    bit from_b;
    from_b = m_ctrl[1] ? m_ctrl[0] : side;
    return from_b ? cs_blk_b[m_frm] : cs_blk_a[m_frm];
  endfunction

  // Slots 4..31 of the expected subframe, slot 4 in bit 0.
  function automatic logic [27:0] exp_word(input bit side);
    logic [27:0] w;
    w = {1'b0, exp_c(side), 1'b0, m_ctrl[3], exp_audio(side)};
    w[27] = ^w[26:0];
    return w;
  endfunction

  function automatic string aud_tag();
    if (m_ctrl[4]) return "R2 muted audio";
    if (m_ctrl[2]) return "R5 mono audio";
    if (m_ctrl[7:6] != 2'b00) return "R10 format ignored audio";
    return "R4 stereo audio";
  endfunction

  task automatic check_par(input bit side);
    chk(aud_tag(), 64'(sf_audio), 64'(exp_audio(side)));
    chk("R3 validity", 64'(sf_v), 64'(m_ctrl[3]));
    chk("R6 status bit", 64'(sf_c), 64'(exp_c(side)));
    chk("R8 parity", 64'(sf_par), 64'(exp_word(side)[27]));
    chk("R9 subframe select", 64'(sf_is_b), 64'(side));
  endtask

  task automatic step(input int i, input bit wr_now, input logic [7:0] wv);
    @(negedge clk);
    if (i == 10) check_par(1'b0);
    if (i == 74) check_par(1'b1);
    cell_en = 1'b1;
    ctrl_wr = wr_now;
    ctrl_wdata = wv;
    @(negedge clk);
    cell_en = 1'b0;
    ctrl_wr = 1'b0;
    lv[i] = tx_line;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  task automatic check_line();
    int bad;
    logic [7:0] got;
    logic [7:0] pat;
    logic [27:0] dec;
    if (m_ctrl[5]) begin
      bad = 0;
      for (int i = 0; i < 128; i++) if (lv[i] !== 1'b0) bad++;
      chk("R1 line held low", 64'(bad), 64'd0);
      return;
    end
    for (int s = 0; s < 2; s++) begin
      int b;
      b = s * 64;
      for (int j = 0; j < 8; j++) got[j] = lv[b + j];
      if (s == 1) pat = 8'b0010_0111;
      else if (m_frm == 0) pat = 8'b0001_0111;
      else pat = 8'b0100_0111;
      chk("R7 preamble", 64'(got), 64'(pat));
      bad = 0;
      for (int k = 4; k < 32; k++) begin
        dec[k - 4] = lv[b + 2 * k] ^ lv[b + 2 * k + 1];
        if (lv[b + 2 * k] === lv[b + 2 * k - 1]) bad++;
      end
      chk("R8 slot edges", 64'(bad), 64'd0);
      chk("R8 decoded word", 64'(dec), 64'(exp_word(s[0])));
    end
  endtask

  initial begin
    logic [7:0] wv;
    bit bwr;
    void'($urandom(32'd2024));
    for (int w = 0; w < 6; w++) begin
      cs_blk_a[w * 32 +: 32] = $urandom;
      cs_blk_b[w * 32 +: 32] = $urandom;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset line", 64'(tx_line), 64'd0);
    chk("R11 reset audio", 64'(sf_audio), 64'd0);
    chk("R11 reset validity", 64'(sf_v), 64'd0);
    chk("R11 reset subframe", 64'(sf_is_b), 64'd0);
    m_ctrl = '0; m_pend = '0; m_a = '0; m_b = '0; m_frm = 0;

    for (int k = 0; k < NFRAMES; k++) begin
      bwr = (k % 17 == 5);
      for (int i = 0; i < 128; i++) begin
        if (i == 40) begin
          case (k + 1)
            1: wv = 8'h00;  2: wv = 8'h10;  3: wv = 8'h08;  4: wv = 8'h04;
            5: wv = 8'h05;  6: wv = 8'h02;  7: wv = 8'h03;  8: wv = 8'h20;
            9: wv = 8'hC0;  10: wv = 8'h40; 11: wv = 8'h8F; 12: wv = 8'h07;
            default: begin
              wv = 8'($urandom);
              if ($urandom % 6 != 0) wv[5] = 1'b0;
            end
          endcase
          @(negedge clk);
          ctrl_wr = 1'b1;
          ctrl_wdata = wv;
          if (k == 2) begin
            smp_a_in = 24'hFFFFFF; smp_b_in = 24'h000001;
          end else if (k == 4) begin
            smp_a_in = 24'h800000; smp_b_in = 24'h7FFFFF;
          end else begin
            smp_a_in = 24'($urandom); smp_b_in = 24'($urandom);
          end
          @(negedge clk);
          ctrl_wr = 1'b0;
          m_pend = wv;
        end
        if (i == 127 && bwr) step(i, 1'b1, 8'($urandom) & 8'hDF);
        else step(i, 1'b0, 8'h00);
      end
      check_line();
      m_ctrl = m_pend;
      if (bwr) m_pend = ctrl_wdata_last();
      m_a = smp_a_in;
      m_b = smp_b_in;
      m_frm = (m_frm == FRAMES - 1) ? 0 : m_frm + 1;
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Records the last byte driven on the write port during a strobe.
  logic [7:0] last_wr;
  always @(posedge clk) if (ctrl_wr) last_wr <= ctrl_wdata;
  function automatic logic [7:0] ctrl_wdata_last();
    return last_wr;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the run finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule